// File: doc/BRIEF.md
# Stack-based recursive function evaluator

The block evaluates the doubly recursive integer function f(0) = 1, f(1) = 1, f(n) = 1 + f(n-1) + f(n-2) without unrolling the recursion into hardware copies. It keeps an explicit stack of continuation frames in registers. Each frame pairs a tag that names where to resume with one saved integer. The engine advances exactly one step per clock. Each step is either an evaluation of the current argument, a resumption at a popped frame, or the final return.

A caller places an unsigned argument on `n_i` and pulses `start_i` while the engine is idle. When the outermost call returns, `result_o` carries the value and `done_o` pulses for one cycle. If the recursion would need more frames than the stack holds, the engine abandons the call, pulses `done_o`, and raises a sticky `overflow_o` flag. All arithmetic wraps modulo 2^WIDTH.

Top module: `rec_eval_engine`

## Requirements
- R1: While `rst_ni` is low, `result_o`, `done_o` and `overflow_o` are all 0.
- R2: An argument of 0 or 1 yields `result_o` = 1, with `done_o` high after the third rising edge, counting the edge that accepts `start_i` as the first.
- R3: An argument of DEPTH+2 or more aborts the call. `done_o` pulses after rising edge DEPTH+2, and `overflow_o` rises in the same cycle and stays high until reset. `result_o` keeps its previous value, and the stack is left empty.
- R4: For 2 <= n <= DEPTH+1, `result_o` equals 1 + f(n-1) + f(n-2) with f(0) = f(1) = 1, and the stack is empty whenever `done_o` is high.
- R5: The completion latency is 2 + T(n) rising edges, where T(0) = T(1) = 1 and T(n) = T(n-1) + T(n-2) + 3. For example, n = 2 gives 3 after 7 edges.
- R6: `done_o` is high for exactly one cycle per completed or aborted call, and `result_o` changes only in a cycle where `done_o` is high.
- R7: A `start_i` pulse while a call is in progress is ignored. The running call's result and latency are unchanged.
- R8: After an overflow, new calls evaluate normally while `overflow_o` stays high. Only reset clears `overflow_o`.
- R9: Sums wrap modulo 2^WIDTH. With WIDTH = 8, n = 11 gives 287 mod 256 = 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only when idle |
| n_i | input | WIDTH | Unsigned argument |
| result_o | output | WIDTH | Value of the last completed call |
| done_o | output | 1 | One-cycle completion or abort pulse |
| overflow_o | output | 1 | Sticky stack overflow flag |

## Verification
The bench builds the engine with WIDTH = 8 and DEPTH = 10. The narrow width makes modular wraparound appear at n = 11, which is the deepest argument that still fits the stack. The shallow depth brings the overflow abort within reach at n = 12, after only twelve cycles. With these values, every argument from 0 up to the depth limit can be swept against a software model of both value and latency. The sequence also covers the abort and recovery after it.

// File: rtl/rec_eval_pkg.sv
package rec_eval_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EVAL = 2'd1,
    ST_RET  = 2'd2
  } state_e;

  // resume points: after first sub-call / after second sub-call
  typedef enum logic {
    TAG_S1 = 1'b0,
    TAG_S2 = 1'b1
  } tag_e;

endpackage

// File: rtl/rec_frame_stack.sv
module rec_frame_stack
  import rec_eval_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             repl_i,
  input  tag_e             wr_tag_i,
  input  logic [WIDTH-1:0] wr_val_i,
  output tag_e             top_tag_o,
  output logic [WIDTH-1:0] top_val_o,
  output logic [CW-1:0]    cnt_o,
  output logic             full_o,
  output logic             empty_o
);

  tag_e             tag_mem [DEPTH];
  logic [WIDTH-1:0] val_mem [DEPTH];
  logic [CW-1:0]    cnt_q;
  logic [AW-1:0]    wr_idx;
  logic [AW-1:0]    top_idx;

  assign top_idx = AW'(cnt_q - CW'(1));
  assign wr_idx  = push_i ? AW'(cnt_q) : top_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (push_i) begin
      cnt_q <= cnt_q + CW'(1);
    end else if (pop_i) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  // storage needs no reset: only written slots are ever read
  always_ff @(posedge clk_i) begin
    if (push_i || repl_i) begin
      tag_mem[wr_idx] <= wr_tag_i;
      val_mem[wr_idx] <= wr_val_i;
    end
  end

  assign top_tag_o = tag_mem[top_idx];
  assign top_val_o = val_mem[top_idx];
  assign cnt_o     = cnt_q;
  assign full_o    = (cnt_q == CW'(DEPTH));
  assign empty_o   = (cnt_q == '0);

endmodule

// File: rtl/rec_step_logic.sv
module rec_step_logic
  import rec_eval_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  state_e           state_i,
  input  logic [WIDTH-1:0] acc_i,
  input  logic             start_i,
  input  logic [WIDTH-1:0] n_i,
  input  logic             full_i,
  input  logic             empty_i,
  input  tag_e             top_tag_i,
  input  logic [WIDTH-1:0] top_val_i,
  output state_e           state_o,
  output logic [WIDTH-1:0] acc_o,
  output logic             push_o,
  output logic             pop_o,
  output logic             repl_o,
  output tag_e             wr_tag_o,
  output logic [WIDTH-1:0] wr_val_o,
  output logic             fin_o,
  output logic             ovf_o
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
  localparam logic [WIDTH-1:0] TWO = WIDTH'(2);

  // acc holds the argument in ST_EVAL and the returned value in ST_RET
  always_comb begin
    state_o  = state_i;
    acc_o    = acc_i;
    push_o   = 1'b0;
    pop_o    = 1'b0;
    repl_o   = 1'b0;
    wr_tag_o = TAG_S1;
    wr_val_o = acc_i;
    fin_o    = 1'b0;
    ovf_o    = 1'b0;
    unique case (state_i)
      ST_IDLE: begin
        if (start_i) begin
          acc_o   = n_i;
          state_o = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (acc_i <= ONE) begin
          acc_o   = ONE;
          state_o = ST_RET;
        end else if (full_i) begin
          ovf_o   = 1'b1;
          fin_o   = 1'b1;
          state_o = ST_IDLE;
        end else begin
          push_o   = 1'b1;
          wr_tag_o = TAG_S1;
          wr_val_o = acc_i;
          acc_o    = acc_i - ONE;
        end
      end
      ST_RET: begin
        if (empty_i) begin
          fin_o   = 1'b1;
          state_o = ST_IDLE;
        end else if (top_tag_i == TAG_S1) begin
          // swap frame in place: keep r1, evaluate saved n minus two
          repl_o   = 1'b1;
          wr_tag_o = TAG_S2;
          wr_val_o = acc_i;
          acc_o    = top_val_i - TWO;
          state_o  = ST_EVAL;
        end else begin
          pop_o = 1'b1;
          acc_o = acc_i + top_val_i + ONE;
        end
      end
      default: state_o = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/rec_eval_engine.sv
module rec_eval_engine
  import rec_eval_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] n_i,
  output logic [WIDTH-1:0] result_o,
  output logic             done_o,
  output logic             overflow_o
);

  state_e           state_q, state_d;
  logic [WIDTH-1:0] acc_q, acc_d;
  logic [WIDTH-1:0] result_q;
  logic             done_q, ovf_q;

  logic             push, pop, repl, fin, ovf;
  tag_e             wr_tag, top_tag;
  logic [WIDTH-1:0] wr_val, top_val;
  logic [CW-1:0]    stk_cnt;
  logic             stk_full, stk_empty;

  rec_frame_stack #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_stack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (ovf),
    .push_i    (push),
    .pop_i     (pop),
    .repl_i    (repl),
    .wr_tag_i  (wr_tag),
    .wr_val_i  (wr_val),
    .top_tag_o (top_tag),
    .top_val_o (top_val),
    .cnt_o     (stk_cnt),
    .full_o    (stk_full),
    .empty_o   (stk_empty)
  );

  rec_step_logic #(.WIDTH(WIDTH)) u_step (
    .state_i   (state_q),
    .acc_i     (acc_q),
    .start_i   (start_i),
    .n_i       (n_i),
    .full_i    (stk_full),
    .empty_i   (stk_empty),
    .top_tag_i (top_tag),
    .top_val_i (top_val),
    .state_o   (state_d),
    .acc_o     (acc_d),
    .push_o    (push),
    .pop_o     (pop),
    .repl_o    (repl),
    .wr_tag_o  (wr_tag),
    .wr_val_o  (wr_val),
    .fin_o     (fin),
    .ovf_o     (ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      acc_q    <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      acc_q   <= acc_d;
      done_q  <= fin;
      if (fin && !ovf) result_q <= acc_q;
      if (ovf)         ovf_q    <= 1'b1;
    end
  end

  assign result_o   = result_q;
  assign done_o     = done_q;
  assign overflow_o = ovf_q;

endmodule

// File: rtl/rec_eval_chk.sv
module rec_eval_chk #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             done_o,
  input logic             overflow_o,
  input logic [WIDTH-1:0] result_o,
  input logic [CW-1:0]    stk_cnt_i
);

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_result_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  assert_ovf_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  assert_ovf_with_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> done_o);

  assert_stack_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_cnt_i <= CW'(DEPTH));

  assert_empty_at_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (stk_cnt_i == '0));

endmodule

bind rec_eval_engine rec_eval_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .done_o     (done_o),
  .overflow_o (overflow_o),
  .result_o   (result_o),
  .stk_cnt_i  (stk_cnt)
);

// File: tb/tb_rec_eval_engine.sv
module tb_rec_eval_engine;

  localparam int W = 8;
  localparam int D = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [W-1:0] n_i = '0;
  logic [W-1:0] result_o;
  logic         done_o;
  logic         overflow_o;

  int total = 0;
  int bad = 0;
  int cyc_all = 0;

  rec_eval_engine #(.WIDTH(W), .DEPTH(D)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .n_i(n_i),
    .result_o(result_o), .done_o(done_o), .overflow_o(overflow_o)
  );

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc_all++;
    if (cyc_all > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc_all);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ref_f(input int n);
    int a = 1, b = 1, c;
    if (n <= 1) return 1;
    for (int k = 2; k <= n; k++) begin
      c = (1 + a + b) % (1 << W);
      a = b; b = c;
    end
    return b;
  endfunction

  function automatic int ref_t(input int n);
    int a = 1, b = 1, c;
    if (n <= 1) return 1;
    for (int k = 2; k <= n; k++) begin
      c = a + b + 3;
      a = b; b = c;
    end
    return b;
  endfunction

  // optional busy strobe at cycle busy_at (0 = none)
  task automatic run(input int n, input int busy_at, output int res,
                     output int lat, output bit got);
    @(negedge clk_i);
    start_i = 1'b1; n_i = W'(n);
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 5000) begin
      if (busy_at != 0 && lat == busy_at) begin
        start_i = 1'b1; n_i = '0;
      end
      @(negedge clk_i);
      start_i = 1'b0;
      lat++;
    end
    got = done_o;
    res = int'(result_o);
  endtask

  task automatic t_reset();
    #1;
    check(result_o == '0, "R1", "result in reset", int'(result_o), 0);
    check(done_o == 1'b0, "R1", "done in reset", int'(done_o), 0);
    check(overflow_o == 1'b0, "R1", "overflow in reset", int'(overflow_o), 0);
  endtask

  task automatic t_sweep();
    int res, lat; bit got;
    for (int n = 0; n <= D + 1; n++) begin
      run(n, 0, res, lat, got);
      check(got, (n <= 1) ? "R2" : "R4", "done seen", int'(got), 1);
      check(res == ref_f(n), (n <= 1) ? "R2" : (n == 11 ? "R9" : "R4"),
            $sformatf("value n=%0d", n), res, ref_f(n));
      check(lat == 2 + ref_t(n), "R5", $sformatf("latency n=%0d", n), lat, 2 + ref_t(n));
      @(negedge clk_i);
      check(done_o == 1'b0, "R6", "done width", int'(done_o), 0);
      check(overflow_o == 1'b0, "R4", "no overflow", int'(overflow_o), 0);
    end
  endtask

  task automatic t_overflow();
    int res, lat; bit got;
    run(D + 2, 0, res, lat, got);
    check(got, "R3", "abort done", int'(got), 1);
    check(lat == D + 2, "R3", "abort latency", lat, D + 2);
    check(overflow_o == 1'b1, "R3", "flag raised", int'(overflow_o), 1);
    check(res == ref_f(D + 1), "R3", "result kept", res, ref_f(D + 1));
    @(negedge clk_i);
    check(done_o == 1'b0, "R6", "abort done width", int'(done_o), 0);
  endtask

  task automatic t_after_overflow();
    int res, lat; bit got;
    run(3, 0, res, lat, got);
    check(res == 5, "R8", "value after abort", res, 5);
    check(lat == 2 + ref_t(3), "R8", "latency after abort", lat, 2 + ref_t(3));
    check(overflow_o == 1'b1, "R8", "flag sticky", int'(overflow_o), 1);
    run(2, 0, res, lat, got);
    check(res == 3 && lat == 7, "R5", "n=2 result", res, 3);
  endtask

  task automatic t_busy_start();
    int res, lat; bit got;
    run(5, 3, res, lat, got);
    check(res == 15, "R7", "value with busy start", res, 15);
    check(lat == 2 + ref_t(5), "R7", "latency with busy start", lat, 2 + ref_t(5));
    repeat (3) @(negedge clk_i);
    check(done_o == 1'b0, "R7", "no extra done", int'(done_o), 0);
    check(result_o == W'(15), "R6", "result held", int'(result_o), 15);
  endtask

  task automatic t_reset_clears();
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(overflow_o == 1'b0, "R8", "reset clears flag", int'(overflow_o), 0);
    check(result_o == '0, "R1", "reset clears result", int'(result_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    t_reset();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    t_sweep();
    t_overflow();
    t_after_overflow();
    t_busy_start();
    t_reset_clears();
    begin
      int res, lat; bit got;
      run(0, 0, res, lat, got);
      check(res == 1 && lat == 3, "R2", "n=0 after reset", lat, 3);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule